// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block profiles how long a processor keeps its two interrupt mask bits set. One bit is the ordinary maskable-interrupt mask and the other is the non-maskable-request mask. A free-running cycle count is fed in from outside. On each sample strobe, a tracker for each bit compares the bit with its own state. When the bit is found set, the tracker records the count at which masking began. When the bit is found clear again, the tracker turns the elapsed count into a duration. It then folds that duration into a running shortest and a running longest value.

Debug software or a profiling harness reads the four results directly from the output ports. It can raise a snapshot request while a masked stretch is still in progress, so that the stretch so far is counted in the longest value. Every tracker has two states:
- `TRK_IDLE`: no interval is open.
- `TRK_OPEN`: an interval is open, and its start count is held in a register. An explicit state bit marks the open condition, so no sentinel value of the start register is needed.

Each tracker has two transitions:
- *open*, from `TRK_IDLE` to `TRK_OPEN`: the strobe is high and the bit is set.
- *close*, from `TRK_OPEN` to `TRK_IDLE`: the strobe is high and the bit is clear.

Top module: `mask_span_monitor`

## Requirements
- R1: After reset, both trackers are in `TRK_IDLE`. The stored shortest value is all ones, and each reported longest value is 0.
- R2: With the strobe high in `TRK_IDLE` and the bit set, the current count is stored as the interval start and the tracker takes the *open* transition.
- R3: With the strobe low and no snapshot request, no output changes, whatever the mask bits and the count do.
- R4: With the strobe high in `TRK_OPEN` and the bit clear, the duration is the count minus the start. The shortest value becomes the smaller of itself and the duration, and the longest value becomes the larger of the two. The tracker then takes the *close* transition.
- R5: A strobe in `TRK_OPEN` with the bit still set leaves the start unchanged, so the interval is measured from its first set sample.
- R6: The two trackers are fully independent. Activity on one bit never changes the other bit's outputs.
- R7: A snapshot request in `TRK_OPEN` replaces the longest value with the elapsed count if the elapsed count is larger. It never lowers the longest value and never changes the stored shortest value.
- R8: A snapshot request in `TRK_IDLE` has no effect.
- R9: While the stored shortest value is still all ones, the reported shortest value equals the reported longest value.
- R10: If the count is below the start when a duration or elapsed count is formed, the result saturates to all ones instead of wrapping.
- R11: When a close and a snapshot request fall in the same cycle, the close takes precedence, so the shortest value is still updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 1 | Strobe that evaluates both mask bits |
| snap | input | 1 | Snapshot request that folds open intervals into the longest value |
| mask_i | input | 1 | Maskable-interrupt mask bit |
| mask_x | input | 1 | Non-maskable-request mask bit |
| cnt | input | CNT_W | Free-running cycle count |
| i_min | output | CNT_W | Reported shortest masked interval, maskable bit |
| i_max | output | CNT_W | Longest masked interval, maskable bit |
| x_min | output | CNT_W | Reported shortest masked interval, non-maskable bit |
| x_max | output | CNT_W | Longest masked interval, non-maskable bit |

## Verification
The bench builds the block with `CNT_W` set to 8. This narrow count puts the all-ones saturation value and the reset sentinel for the shortest value within easy reach. A sweep over the whole 8-bit start range uses interval lengths that cross the count boundary. Each expected duration is computed arithmetically, taking saturation into account. Directed sequences also cover the strobe-less cycles, snapshots in both states, and a close that coincides with a snapshot.

// File: rtl/msm_pkg.sv
package msm_pkg;

    // Per-bit tracker state: no interval open, or an interval in progress.
    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_OPEN = 1'b1
    } trk_state_e;

    // Number of mask bits observed by the monitor.
    localparam int NUM_TRK = 2;

endpackage

// File: rtl/msm_span.sv
// Saturating elapsed-count calculation: now - origin, or all ones if now < origin.
module msm_span #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] now,
    input  logic [CNT_W-1:0] origin,
    output logic [CNT_W-1:0] span
);
    localparam logic [CNT_W-1:0] SAT = '1;

    always_comb begin
        if (now >= origin) begin
            span = now - origin;
        end else begin
            span = SAT;
        end
    end
endmodule

// File: rtl/msm_tracker.sv
// One mask-bit tracker: open/close FSM plus shortest/longest statistics.
module msm_tracker
    import msm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             snap,
    input  logic             mask_bit,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] min_q,
    output logic [CNT_W-1:0] max_q
);
    localparam logic [CNT_W-1:0] MIN_INIT = '1;

    trk_state_e       state_q;
    trk_state_e       state_d;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] span;
    logic             opening;
    logic             closing;
    logic             peeking;

    msm_span #(.CNT_W(CNT_W)) u_span (
        .now    (cnt),
        .origin (start_q),
        .span   (span)
    );

    assign opening = sample && (state_q == TRK_IDLE) && mask_bit;
    assign closing = sample && (state_q == TRK_OPEN) && !mask_bit;
    assign peeking = snap   && (state_q == TRK_OPEN) && !closing;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: if (opening) state_d = TRK_OPEN;
            TRK_OPEN: if (closing) state_d = TRK_IDLE;
            default:  state_d = TRK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output / datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            min_q   <= MIN_INIT;
            max_q   <= '0;
        end else begin
            if (opening) begin
                start_q <= cnt;
            end
            if (closing) begin
                if (span < min_q) min_q <= span;
                if (span > max_q) max_q <= span;
            end else if (peeking) begin
                if (span > max_q) max_q <= span;
            end
        end
    end
endmodule

// File: rtl/msm_report.sv
// Reporting view: substitute the longest value while the shortest is still at its sentinel.
module msm_report #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] raw_min,
    input  logic [CNT_W-1:0] raw_max,
    output logic [CNT_W-1:0] rep_min
);
    localparam logic [CNT_W-1:0] SENTINEL = '1;

    always_comb begin
        if (raw_min == SENTINEL) begin
            rep_min = raw_max;
        end else begin
            rep_min = raw_min;
        end
    end
endmodule

// File: rtl/mask_span_monitor.sv
module mask_span_monitor
    import msm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             snap,
    input  logic             mask_i,
    input  logic             mask_x,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] i_min,
    output logic [CNT_W-1:0] i_max,
    output logic [CNT_W-1:0] x_min,
    output logic [CNT_W-1:0] x_max
);
    logic [NUM_TRK-1:0] mask_vec;
    logic [CNT_W-1:0]   raw_min [NUM_TRK];
    logic [CNT_W-1:0]   raw_max [NUM_TRK];
    logic [CNT_W-1:0]   rep_min [NUM_TRK];

    assign mask_vec = {mask_x, mask_i};

    for (genvar g = 0; g < NUM_TRK; g++) begin : g_trk
        msm_tracker #(.CNT_W(CNT_W)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample   (sample),
            .snap     (snap),
            .mask_bit (mask_vec[g]),
            .cnt      (cnt),
            .min_q    (raw_min[g]),
            .max_q    (raw_max[g])
        );

        msm_report #(.CNT_W(CNT_W)) u_rep (
            .raw_min (raw_min[g]),
            .raw_max (raw_max[g]),
            .rep_min (rep_min[g])
        );
    end

    assign i_min = rep_min[0];
    assign i_max = raw_max[0];
    assign x_min = rep_min[1];
    assign x_max = raw_max[1];
endmodule

// File: rtl/msm_checker.sv
module msm_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample,
    input logic             snap,
    input logic [CNT_W-1:0] i_min,
    input logic [CNT_W-1:0] i_max,
    input logic [CNT_W-1:0] x_min,
    input logic [CNT_W-1:0] x_max
);
    a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !snap) |=> ($stable(i_min) && $stable(i_max) &&
                                $stable(x_min) && $stable(x_max)));

    a_r4_i_max_mono: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (i_max >= $past(i_max)));

    a_r4_x_max_mono: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (x_max >= $past(x_max)));

    a_r9_i_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        i_min <= i_max);

    a_r9_x_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        x_min <= x_max);
endmodule

bind mask_span_monitor msm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (sample),
    .snap   (snap),
    .i_min  (i_min),
    .i_max  (i_max),
    .x_min  (x_min),
    .x_max  (x_max)
);

// File: tb/tb_mask_span_monitor.sv
`timescale 1ns/1ps
module tb_mask_span_monitor;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample = 1'b0;
    logic         snap = 1'b0;
    logic         mask_i = 1'b0;
    logic         mask_x = 1'b0;
    logic [W-1:0] cnt = '0;
    logic [W-1:0] i_min, i_max, x_min, x_max;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mask_span_monitor #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .sample(sample), .snap(snap),
        .mask_i(mask_i), .mask_x(mask_x), .cnt(cnt),
        .i_min(i_min), .i_max(i_max), .x_min(x_min), .x_max(x_max)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit s, input bit mi, input bit mx, input int c, input bit sn);
        @(negedge clk);
        sample = s; mask_i = mi; mask_x = mx; cnt = c[W-1:0]; snap = sn;
        @(negedge clk);
        sample = 1'b0; snap = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sample = 1'b0; snap = 1'b0; mask_i = 1'b0; mask_x = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int em;
        int eM;
        int st;
        int en;
        int dur;
        do_reset();
        // R1 reset state
        check("R1 i_min", int'(i_min), 0);
        check("R1 i_max", int'(i_max), 0);
        check("R1 x_min", int'(x_min), 0);
        check("R1 x_max", int'(x_max), 0);

        // R3 strobe low: mask toggles are ignored
        step(0, 1, 1, 3, 0);
        step(0, 0, 0, 4, 0);
        check("R3 i_max", int'(i_max), 0);
        check("R3 x_max", int'(x_max), 0);

        // R2/R5 open at 10, held set at 12, strobe-less clear at 13, close at 30
        step(1, 1, 0, 10, 0);
        step(1, 1, 0, 12, 0);
        step(0, 0, 0, 13, 0);
        check("R3 i_max while open", int'(i_max), 0);
        step(1, 0, 0, 30, 0);
        check("R2 R5 i_max", int'(i_max), 20);
        check("R1 R4 i_min", int'(i_min), 20);
        check("R6 x_max", int'(x_max), 0);

        // R4 shorter then longer interval
        step(1, 1, 0, 40, 0);
        step(1, 0, 0, 45, 0);
        check("R4 i_min", int'(i_min), 5);
        check("R4 i_max", int'(i_max), 20);
        step(1, 1, 0, 50, 0);
        step(1, 0, 0, 90, 0);
        check("R4 i_max longer", int'(i_max), 40);
        check("R4 i_min kept", int'(i_min), 5);

        // R8 snapshot while idle
        step(0, 0, 0, 250, 1);
        check("R8 i_max", int'(i_max), 40);
        check("R8 x_max", int'(x_max), 0);

        // R9 on X: open at 100, snapshot at 160
        step(1, 0, 1, 100, 0);
        step(0, 0, 1, 160, 1);
        check("R7 x_max", int'(x_max), 60);
        check("R9 x_min fallback", int'(x_min), 60);
        check("R6 i_max", int'(i_max), 40);
        step(0, 0, 1, 130, 1);
        check("R7 x_max not lowered", int'(x_max), 60);
        step(1, 0, 0, 110, 0);
        check("R4 x_min", int'(x_min), 10);
        check("R4 x_max", int'(x_max), 60);

        // R7 on I: snapshot raises max, min unchanged
        step(1, 1, 0, 100, 0);
        step(0, 1, 0, 150, 1);
        check("R7 i_max", int'(i_max), 50);
        check("R7 i_min", int'(i_min), 5);
        step(1, 0, 0, 170, 0);
        check("R4 i_max after close", int'(i_max), 70);

        // R11 close and snapshot in the same cycle
        step(1, 1, 0, 200, 0);
        step(1, 0, 0, 202, 1);
        check("R11 i_min", int'(i_min), 2);
        check("R11 i_max", int'(i_max), 70);

        // R10 saturation on X: start 200, count 50
        step(1, 0, 1, 200, 0);
        step(1, 0, 0, 50, 0);
        check("R10 x_max", int'(x_max), 255);
        check("R10 x_min", int'(x_min), 10);

        // Sweep across the start range with wrapping lengths (R4, R9, R10)
        do_reset();
        em = 255; eM = 0;
        for (int s = 0; s < 256; s += 3) begin
            st = s;
            en = (s + ((s * 7 + 1) % 256)) % 256;
            dur = (en >= st) ? (en - st) : 255;
            if (dur < em) em = dur;
            if (dur > eM) eM = dur;
            step(1, 1, 0, st, 0);
            step(1, 0, 0, en, 0);
            check("R10 sweep i_max", int'(i_max), eM);
            check("R9 sweep i_min", int'(i_min), (em == 255) ? eM : em);
        end
        check("R6 sweep x_max", int'(x_max), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule